// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate

This block sits between a host's memory chip-enable line and an external memory, beside the access controller of a serially unlocked timekeeper. It takes a power-fail flag from an external supply comparator, resynchronises it, and decides two things. The first is how the memory chip-enable output behaves. The second is whether the clock registers may be reached. While supply is good, the memory enable follows the host enable. The exception is the cycles the access controller claims for its unlock and transfer sequence, during which the memory is kept deselected. While supply is bad, the memory enable is forced to a level chosen by a mode input. It is held high (write-protected) for a RAM and driven low for a ROM.

The supervisor is a three-state machine. `ST_GOOD` allows access. `ST_FAIL` blocks access while the synchronised flag is high. `ST_RECOVER` keeps access blocked for a programmable number of clock cycles after the flag clears. The transitions are:
- `GOOD->FAIL` when the flag is seen. This emits a one-cycle abort pulse.
- `FAIL->RECOVER` when the flag clears with a non-zero recovery count.
- `FAIL->GOOD` when the flag clears with a zero recovery count.
- `RECOVER->FAIL` when the flag comes back.
- `RECOVER->GOOD` when the count runs out.

An external reset pin is also synchronised. Unless a reset-mask bit is set, a low level on the pin raises the transfer-abort output. The pin acts on this output independently of the power state. The mode pin applies only to the memory enable. Clock-register access is blocked in both modes.

Top module: `pwrfail_ce_gate`

## Requirements
- R1: While `rst_n` is low, `access_en` is 0 and `fail_abort` is 0. `ce_out_n` shows the forced level for the current mode, because the block comes out of reset assuming bad power.
- R2: With `access_en`=1 and `seq_claim`=0, `ce_out_n` equals `ce_in_n` in the same cycle.
- R3: With `access_en`=1 and `seq_claim`=1, `ce_out_n` is 1.
- R4: With `access_en`=0 and `rom_sel`=0 (RAM mode), `ce_out_n` is 1 whatever `ce_in_n` and `seq_claim` are.
- R5: With `access_en`=0 and `rom_sel`=1 (ROM mode), `ce_out_n` is 0 whatever `ce_in_n` and `seq_claim` are.
- R6: `pf_async` passes through a two-flop synchronizer. Suppose it rises before clock edge E1 while access is allowed. Then `access_en` falls and `fail_abort` goes high after edge E3, and `fail_abort` is back to 0 after edge E4. `fail_abort` is never high for two cycles in a row.
- R7: Suppose `pf_async` falls before edge E1 while access is blocked and stays low. Then `access_en` rises after edge E3+N, where N is the value on `recov_cycles` at edge E3. For N=0, it rises after edge E3.
- R8: If the synchronised flag returns during the recovery count, access stays blocked, the count restarts from the full value on the next recovery, and no `fail_abort` pulse is produced.
- R9: `ext_rst_n` passes through a two-flop synchronizer. With `rst_mask`=0, a low level on `ext_rst_n` before edge E1 sets `xfer_abort`=1 after edge E2. It holds there while the pin stays low.
- R10: With `rst_mask`=1, the reset pin is ignored. `xfer_abort` follows only `fail_abort`, and `access_en` and `ce_out_n` are unaffected.
- R11: `xfer_abort` is 1 in every cycle in which `fail_abort` is 1.
- R12: The forced `ce_out_n` level of R4 and R5 also applies during the recovery count, not only while the flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pf_async | input | 1 | Power-fail flag from the external comparator, asynchronous, 1 = supply bad |
| rom_sel | input | 1 | Memory type: 1 = ROM, 0 = RAM |
| ce_in_n | input | 1 | Host memory chip-enable, active low |
| seq_claim | input | 1 | Access controller is using this cycle for the clock sequence |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| rst_mask | input | 1 | Reset-mask bit from the clock registers, 1 = ignore the pin |
| recov_cycles | input | CNT_W | Cycles that access stays blocked after power returns |
| ce_out_n | output | 1 | Memory chip-enable, active low |
| access_en | output | 1 | Clock-register access allowed |
| fail_abort | output | 1 | One-cycle pulse on entry to power failure |
| xfer_abort | output | 1 | Abort the current serial transfer (power failure pulse or unmasked reset pin) |

## Verification
The bench goes after the exact edge counts of the two synchronizers and of the recovery counter. A design off by one stage or one count would move the `access_en` rise or the abort pulse by one cycle. A zero recovery count is covered separately, because a counter that wraps would block access for a very long time. The bench also flaps the flag in the middle of recovery: a design that pulsed the abort again on re-entry, or that released access early, shows there. Random traffic with mode changes and the reset pin under both mask values would expose an inverted mode level or a mask applied the wrong way.

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;
    typedef enum logic [1:0] {
        ST_GOOD    = 2'd0,
        ST_FAIL    = 2'd1,
        ST_RECOVER = 2'd2
    } gate_state_e;
endpackage

// File: rtl/pwrfail_sync.sv
module pwrfail_sync #(
    parameter int    STAGES  = 2,
    parameter logic  RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pwrfail_fsm.sv
module pwrfail_fsm
    import pwrfail_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pf_s,
    input  logic [CNT_W-1:0] recov_cycles,
    output logic             access_en,
    output logic             gate_on,
    output logic             abort_pulse
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    gate_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             abort_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FAIL;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GOOD:    if (pf_s) state_d = ST_FAIL;
            ST_FAIL:    if (!pf_s) state_d = (recov_cycles == '0) ? ST_GOOD : ST_RECOVER;
            ST_RECOVER: begin
                if (pf_s)                 state_d = ST_FAIL;
                else if (cnt_q == CNT_ONE) state_d = ST_GOOD;
            end
            default:    state_d = ST_FAIL;
        endcase
    end

    // recovery counter and abort pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            abort_q <= 1'b0;
        end else begin
            abort_q <= (state_q == ST_GOOD) && pf_s;
            if (state_q == ST_FAIL && !pf_s)
                cnt_q <= recov_cycles;
            else if (state_q == ST_RECOVER && !pf_s && cnt_q != '0)
                cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // outputs
    always_comb begin
        access_en   = (state_q == ST_GOOD);
        gate_on     = !access_en;
        abort_pulse = abort_q;
    end

    // R6
    abort_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |=> !abort_q);
    // R6
    abort_from_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GOOD && pf_s) |=> (abort_q && state_q == ST_FAIL));
    // R7
    no_access_after_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_s |=> !access_en);
    // R8
    no_abort_in_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_GOOD) |=> !abort_q);
endmodule

// File: rtl/pwrfail_ce_mux.sv
module pwrfail_ce_mux (
    input  logic gate_on,
    input  logic rom_sel,
    input  logic ce_in_n,
    input  logic seq_claim,
    output logic ce_out_n
);
    always_comb begin
        if (gate_on) ce_out_n = !rom_sel;
        else         ce_out_n = ce_in_n | seq_claim;
    end
endmodule

// File: rtl/pwrfail_rst_merge.sv
module pwrfail_rst_merge (
    input  logic rst_pin_s_n,
    input  logic rst_mask,
    input  logic abort_pulse,
    output logic xfer_abort
);
    logic pin_hit;

    always_comb begin
        pin_hit    = !rst_pin_s_n && !rst_mask;
        xfer_abort = abort_pulse | pin_hit;
    end
endmodule

// File: rtl/pwrfail_ce_gate.sv
module pwrfail_ce_gate #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pf_async,
    input  logic             rom_sel,
    input  logic             ce_in_n,
    input  logic             seq_claim,
    input  logic             ext_rst_n,
    input  logic             rst_mask,
    input  logic [CNT_W-1:0] recov_cycles,
    output logic             ce_out_n,
    output logic             access_en,
    output logic             fail_abort,
    output logic             xfer_abort
);
    logic pf_s;
    logic rst_pin_s_n;
    logic gate_on;

    pwrfail_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pf_sync (
        .clk(clk), .rst_n(rst_n), .d(pf_async), .q(pf_s));

    pwrfail_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_rst_n), .q(rst_pin_s_n));

    pwrfail_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pf_s(pf_s), .recov_cycles(recov_cycles),
        .access_en(access_en), .gate_on(gate_on), .abort_pulse(fail_abort));

    pwrfail_ce_mux u_ce_mux (
        .gate_on(gate_on), .rom_sel(rom_sel), .ce_in_n(ce_in_n),
        .seq_claim(seq_claim), .ce_out_n(ce_out_n));

    pwrfail_rst_merge u_rst_merge (
        .rst_pin_s_n(rst_pin_s_n), .rst_mask(rst_mask),
        .abort_pulse(fail_abort), .xfer_abort(xfer_abort));

    // R4
    ram_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_en && !rom_sel) |-> ce_out_n);
    // R5
    rom_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_en && rom_sel) |-> !ce_out_n);
    // R3
    claim_hides_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access_en && seq_claim) |-> ce_out_n);
    // R11
    abort_reaches_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_abort |-> xfer_abort);
    // R10
    masked_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_mask && !fail_abort) |-> !xfer_abort);
endmodule

// File: tb/pwrfail_ce_gate_test.sv
`timescale 1ns/1ps
module pwrfail_ce_gate_test;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pf_async = 1'b1, rom_sel = 1'b0, ce_in_n = 1'b1, seq_claim = 1'b0;
    logic ext_rst_n = 1'b1, rst_mask = 1'b0;
    logic [CNT_W-1:0] recov_cycles = '0;
    logic ce_out_n, access_en, fail_abort, xfer_abort;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwrfail_ce_gate #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .pf_async(pf_async), .rom_sel(rom_sel),
        .ce_in_n(ce_in_n), .seq_claim(seq_claim), .ext_rst_n(ext_rst_n),
        .rst_mask(rst_mask), .recov_cycles(recov_cycles), .ce_out_n(ce_out_n),
        .access_en(access_en), .fail_abort(fail_abort), .xfer_abort(xfer_abort));

    // reference model built from the requirements
    logic m_pf1, m_pf2, m_r1, m_r2, m_blocked, m_inrec, m_abort;
    int   m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pf1 <= 1'b1; m_pf2 <= 1'b1; m_r1 <= 1'b1; m_r2 <= 1'b1;
            m_blocked <= 1'b1; m_inrec <= 1'b0; m_abort <= 1'b0; m_cnt <= 0;
        end else begin
            m_pf1 <= pf_async; m_pf2 <= m_pf1;
            m_r1 <= ext_rst_n; m_r2 <= m_r1;
            m_abort <= 1'b0;
            if (!m_blocked) begin
                if (m_pf2) begin m_blocked <= 1'b1; m_abort <= 1'b1; end
            end else if (!m_inrec) begin
                if (!m_pf2) begin
                    if (recov_cycles == 0) m_blocked <= 1'b0;
                    else begin m_inrec <= 1'b1; m_cnt <= int'(recov_cycles); end
                end
            end else begin
                if (m_pf2) m_inrec <= 1'b0;
                else if (m_cnt == 1) begin m_blocked <= 1'b0; m_inrec <= 1'b0; end
                else m_cnt <= m_cnt - 1;
            end
        end
    end

    function automatic logic exp_ce(logic blocked, logic rom, logic ce, logic claim);
        if (blocked) return !rom;
        return ce | claim;
    endfunction

    function automatic logic exp_xfer(logic abort, logic pin_s, logic mask);
        return abort | (!pin_s & !mask);
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    task automatic model_checks();
        string ce_req, x_req;
        if (m_blocked) ce_req = rom_sel ? (m_inrec ? "R12" : "R5") : (m_inrec ? "R12" : "R4");
        else ce_req = seq_claim ? "R3" : "R2";
        x_req = rst_mask ? "R10" : (m_abort ? "R11" : "R9");
        check(ce_req, "ce_out_n", ce_out_n, exp_ce(m_blocked, rom_sel, ce_in_n, seq_claim));
        check("R7", "access_en", access_en, !m_blocked);
        check("R6", "fail_abort", fail_abort, m_abort);
        check(x_req, "xfer_abort", xfer_abort, exp_xfer(m_abort, m_r2, rst_mask));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1315));
        // R1: reset state in both modes
        repeat (3) edge_step();
        check("R1", "access_en in reset", access_en, 1'b0);
        check("R1", "fail_abort in reset", fail_abort, 1'b0);
        check("R1", "ram ce_out_n in reset", ce_out_n, 1'b1);
        rom_sel = 1'b1; #1;
        check("R1", "rom ce_out_n in reset", ce_out_n, 1'b0);
        rom_sel = 1'b0;
        edge_step();
        rst_n = 1'b1;

        // R7: power good with N=5, exact release edge
        recov_cycles = 16'd5;
        pf_async = 1'b0;              // before E1
        edge_step(); edge_step();     // E1, E2
        check("R7", "blocked after E2", access_en, 1'b0);
        edge_step();                  // E3: enter recovery
        for (int i = 1; i < 5; i++) edge_step();  // E4..E7
        check("R7", "blocked after E3+4", access_en, 1'b0);
        ce_in_n = 1'b0; #1;
        check("R12", "ram ce forced during recovery", ce_out_n, 1'b1);
        edge_step();                  // E8 = E3+5
        check("R7", "released after E3+N", access_en, 1'b1);
        check("R2", "ce follows input", ce_out_n, 1'b0);
        seq_claim = 1'b1; #1;
        check("R3", "claim hides memory", ce_out_n, 1'b1);
        seq_claim = 1'b0;

        // R6: failing edge latency and single-cycle pulse
        pf_async = 1'b1;              // before E1
        edge_step();
        check("R6", "access after E1", access_en, 1'b1);
        edge_step();
        check("R6", "access after E2", access_en, 1'b1);
        edge_step();
        check("R6", "access after E3", access_en, 1'b0);
        check("R6", "abort after E3", fail_abort, 1'b1);
        check("R11", "xfer follows abort", xfer_abort, 1'b1);
        check("R4", "ram ce forced high", ce_out_n, 1'b1);
        rom_sel = 1'b1; #1;
        check("R5", "rom ce forced low", ce_out_n, 1'b0);
        rom_sel = 1'b0;
        edge_step();
        check("R6", "abort gone after E4", fail_abort, 1'b0);

        // R8: flag returns during recovery
        recov_cycles = 16'd6;
        pf_async = 1'b0;
        repeat (5) edge_step();       // in recovery
        pf_async = 1'b1;
        repeat (3) edge_step();
        check("R8", "blocked after flap", access_en, 1'b0);
        check("R8", "no abort on re-entry", fail_abort, 1'b0);
        pf_async = 1'b0;
        repeat (2) edge_step();       // E1, E2
        edge_step();                  // E3
        for (int i = 1; i < 6; i++) edge_step();
        check("R8", "full count restarts", access_en, 1'b0);
        edge_step();
        check("R8", "release after full count", access_en, 1'b1);

        // R7: zero recovery count
        recov_cycles = 16'd0;
        pf_async = 1'b1;
        repeat (4) edge_step();
        pf_async = 1'b0;
        repeat (2) edge_step();
        check("R7", "N=0 still blocked after E2", access_en, 1'b0);
        edge_step();
        check("R7", "N=0 released after E3", access_en, 1'b1);

        // R9 / R10: external reset pin
        rst_mask = 1'b0;
        ext_rst_n = 1'b0;
        edge_step();
        check("R9", "xfer after E1", xfer_abort, 1'b0);
        edge_step();
        check("R9", "xfer after E2", xfer_abort, 1'b1);
        check("R9", "access kept", access_en, 1'b1);
        rst_mask = 1'b1; #1;
        check("R10", "masked pin ignored", xfer_abort, 1'b0);
        ce_in_n = 1'b0; #1;
        check("R10", "ce unaffected by masked pin", ce_out_n, 1'b0);
        ext_rst_n = 1'b1;
        repeat (3) edge_step();

        // random traffic checked against the model
        for (int i = 0; i < 4000; i++) begin
            edge_step();
            ce_in_n   = 1'($urandom_range(0, 1));
            seq_claim = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 60) == 0) rom_sel = ~rom_sel;
            if ($urandom_range(0, 35) == 0) pf_async = ~pf_async;
            if ($urandom_range(0, 25) == 0) ext_rst_n = ~ext_rst_n;
            if ($urandom_range(0, 80) == 0) rst_mask = ~rst_mask;
            if ($urandom_range(0, 100) == 0) recov_cycles = 16'($urandom_range(0, 12));
            #1;
            model_checks();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule